// File: doc/BRIEF.md
# Serial Codec Register Write Master

This block programs the control registers of a pair of audio converter chips over a three-wire serial link that only writes. It drives one active-low select per chip, a shared clock and a shared data line. A direct request names a chip, a 5-bit register and a data byte. The block builds a 16-bit frame from a fixed 2-bit device address, a write flag, the register and the data. It shifts the frame out most significant bit first. Every line change is spaced by a programmable delay period, counted in system clock cycles. When the lines have settled high again, the block pulses `done`.

The block keeps a shadow byte for every register of every chip. Each transfer updates the shadow with the byte it sent. A masked request needs no chip index: it takes a register, a mask and a value, and writes `(shadow & ~mask) | value` to chip 0 and then to chip 1. Each chip gets its own shadow contents, and `done` pulses once after the last chip. A request that comes while the block is busy is dropped and latches a sticky error flag. A direct request that names a chip that does not exist gets a one-cycle reject pulse and causes no bus activity.

Top module: `codec_wr_master`

## Requirements
- R1: The frame is 16 bits, sent most significant bit first: bits [15:14] = 2'b10 (device address), bit [13] = 1 (write flag), bits [12:8] = register, bits [7:0] = data byte.
- R2: After reset, `busy`, `done`, `reject` and `err` are low, and both selects, the clock and the data line are high.
- R3: After a request is accepted, one cycle of set-up is followed by all lines held high for one delay period. Then only the addressed chip's select (bit 0 for chip 0, bit 1 for chip 1) goes low, and all other lines stay high for one more delay period.
- R4: Each bit takes three phases of one delay period each: clock low, then data set to the bit, then clock high. Data changes only while the clock is low.
- R5: After the last bit's clock-high phase, all lines go high for one delay period. Then `done` pulses for one cycle and `busy` falls in the same cycle.
- R6: A direct request with chip index 2 or 3 pulses `reject` for one cycle the cycle after it is presented. `busy` stays low and no line moves.
- R7: A masked request (`req_masked` = 1) ignores `req_chip`. It writes `(shadow & ~mask) | value` to chip 0 and then to chip 1, each as a complete transfer. `done` pulses only after the second transfer.
- R8: Every transfer stores the byte it sends in that chip's shadow register, and reset clears all shadow registers to zero.
- R9: A request presented while `busy` is high has no effect on the transfer in progress or on any shadow register, and it sets `err`. `err` stays high until reset.
- R10: The delay period is `DLY_CYC` system clock cycles. Its default equals 100 microseconds at `CLK_HZ`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled on a rising edge |
| req_masked | input | 1 | 1 = masked update sent to all chips, 0 = direct write |
| req_chip | input | 2 | Chip index for a direct write |
| req_reg | input | 5 | Register address |
| req_data | input | 8 | Data byte (direct) or OR value (masked) |
| req_mask | input | 8 | Bits to clear from the shadow byte (masked only) |
| busy | output | 1 | A transfer sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| reject | output | 1 | One-cycle pulse for an out-of-range chip index |
| err | output | 1 | Sticky flag: a request arrived while busy |
| cs_n | output | 2 | Active-low chip selects, bit n for chip n |
| sclk | output | 1 | Serial clock; the receiver samples on its rising edge |
| sdata | output | 1 | Serial data |

## Verification
Take an accepted request sampled at edge E, with D the delay period. The select falls after edge E+1+D. Bit i's clock falls after edge E+1+2D+3Di, its data changes D cycles later, and its clock rises 2D cycles later. The lines return high after edge E+1+50D. `done` pulses after edge E+1+51D, and for a masked request the second chip's transfer begins at that same edge instead. `reject` and `err` are due one edge after the request. The bench builds this per-cycle timeline in a queue when the request is issued and pops one entry at every falling clock edge. Each output field is compared there, half a period away from the edge that changed it. A monitor also rebuilds each frame from the clock's rising edges and checks the byte against the bench's own shadow arithmetic.

// File: rtl/codec_wr_pkg.sv
package codec_wr_pkg;
  localparam logic [1:0] DEV_ADDR = 2'b10;
  localparam logic       WR_FLAG  = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PRE,
    ST_SEL,
    ST_CLO,
    ST_DAT,
    ST_CHI,
    ST_POST
  } wr_state_t;
endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int DLY_CYC = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expire
);
  localparam int CW = (DLY_CYC > 1) ? $clog2(DLY_CYC) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(DLY_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CW'(1);
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/shadow_ram.sv
module shadow_ram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DW-1:0]    rd_q;
  logic             rvld_q;

  // storage array: no reset, so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (we)
      mem[addr] <= wdata;
    rd_q <= mem[addr];
  end

  // written-since-reset flags give the cleared-at-reset view
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      rvld_q <= 1'b0;
    end else begin
      if (we)
        vld_q[addr] <= 1'b1;
      rvld_q <= vld_q[addr];
    end
  end

  assign rdata = rvld_q ? rd_q : '0;
endmodule

// File: rtl/codec_wr_master.sv
module codec_wr_master
  import codec_wr_pkg::*;
#(
  parameter int CLK_HZ  = 200_000_000,
  parameter int DLY_CYC = (CLK_HZ / 1_000_000) * 100,
  parameter int NCHIP   = 2,
  parameter int IDX_W   = 2,
  parameter int REG_W   = 5,
  parameter int DAT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_masked,
  input  logic [IDX_W-1:0] req_chip,
  input  logic [REG_W-1:0] req_reg,
  input  logic [DAT_W-1:0] req_data,
  input  logic [DAT_W-1:0] req_mask,
  output logic             busy,
  output logic             done,
  output logic             reject,
  output logic             err,
  output logic [NCHIP-1:0] cs_n,
  output logic             sclk,
  output logic             sdata
);
  localparam int CW      = (NCHIP > 1) ? $clog2(NCHIP) : 1;
  localparam int FRAME_W = 3 + REG_W + DAT_W;
  localparam int BW      = $clog2(FRAME_W);
  localparam int AW      = CW + REG_W;

  wr_state_t        st_q;
  logic [CW-1:0]    chip_q;
  logic             multi_q;
  logic [REG_W-1:0] reg_q;
  logic [DAT_W-1:0] val_q, mask_q, byte_q, new_byte, sh_rdata;
  logic [BW-1:0]    bit_q;
  logic [NCHIP-1:0] cs_n_q;
  logic             sclk_q, sd_q, busy_q, done_q, rej_q, err_q;
  logic             tmr_load, tmr_exp, sh_we;
  logic [FRAME_W-1:0] frame;

  phase_timer #(.DLY_CYC(DLY_CYC)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .expire(tmr_exp)
  );

  assign new_byte = multi_q ? ((sh_rdata & ~mask_q) | val_q) : val_q;
  assign sh_we    = (st_q == ST_PRE) && tmr_exp;

  shadow_ram #(.AW(AW), .DW(DAT_W)) u_shadow (
    .clk(clk), .rst(rst), .we(sh_we), .addr({chip_q, reg_q}),
    .wdata(new_byte), .rdata(sh_rdata)
  );

  assign frame    = {DEV_ADDR, WR_FLAG, reg_q, byte_q};
  assign tmr_load = (st_q == ST_LOAD) ||
                    ((st_q != ST_IDLE) && tmr_exp);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      chip_q  <= '0;
      multi_q <= 1'b0;
      reg_q   <= '0;
      val_q   <= '0;
      mask_q  <= '0;
      byte_q  <= '0;
      bit_q   <= '0;
      cs_n_q  <= '1;
      sclk_q  <= 1'b1;
      sd_q    <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rej_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rej_q  <= 1'b0;
      if (st_q != ST_IDLE && req_valid)
        err_q <= 1'b1;
      case (st_q)
        ST_IDLE: if (req_valid) begin
          if (!req_masked && int'(req_chip) >= NCHIP) begin
            rej_q <= 1'b1;
          end else begin
            busy_q  <= 1'b1;
            multi_q <= req_masked;
            chip_q  <= req_masked ? '0 : req_chip[CW-1:0];
            reg_q   <= req_reg;
            val_q   <= req_data;
            mask_q  <= req_mask;
            st_q    <= ST_LOAD;
          end
        end
        ST_LOAD: st_q <= ST_PRE;
        ST_PRE: if (tmr_exp) begin
          byte_q <= new_byte;
          cs_n_q <= ~(NCHIP'(1) << chip_q);
          bit_q  <= BW'(FRAME_W - 1);
          st_q   <= ST_SEL;
        end
        ST_SEL: if (tmr_exp) begin
          sclk_q <= 1'b0;
          st_q   <= ST_CLO;
        end
        ST_CLO: if (tmr_exp) begin
          sd_q <= frame[bit_q];
          st_q <= ST_DAT;
        end
        ST_DAT: if (tmr_exp) begin
          sclk_q <= 1'b1;
          st_q   <= ST_CHI;
        end
        ST_CHI: if (tmr_exp) begin
          if (bit_q == '0) begin
            cs_n_q <= '1;
            sd_q   <= 1'b1;
            st_q   <= ST_POST;
          end else begin
            bit_q  <= bit_q - BW'(1);
            sclk_q <= 1'b0;
            st_q   <= ST_CLO;
          end
        end
        ST_POST: if (tmr_exp) begin
          if (multi_q && int'(chip_q) != NCHIP - 1) begin
            chip_q <= chip_q + CW'(1);
            st_q   <= ST_LOAD;
          end else begin
            done_q <= 1'b1;
            busy_q <= 1'b0;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign reject = rej_q;
  assign err    = err_q;
  assign cs_n   = cs_n_q;
  assign sclk   = sclk_q;
  assign sdata  = sd_q;

  // R3
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n_q) <= 1);

  // R2
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (cs_n_q == '1 && sclk_q && sd_q));

  // R4
  data_while_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sd_q) && cs_n_q != '1) |-> !sclk_q);

  // R5
  done_settled_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && cs_n_q == '1 && sclk_q && sd_q));

  // R6
  reject_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rej_q |-> (!busy_q && cs_n_q == '1));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: tb/test_codec_wr_master.sv
`timescale 1ns/100ps
module test_codec_wr_master;
  localparam int D = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_masked = 1'b0;
  logic [1:0] req_chip = '0;
  logic [4:0] req_reg = '0;
  logic [7:0] req_data = '0, req_mask = '0;
  logic       busy, done, reject, err, sclk, sdata;
  logic [1:0] cs_n;

  int checks = 0, failures = 0, cyc = 0;

  // expected vector: {busy, done, reject, cs_n[1:0], sclk, sdata}
  logic [6:0]  expq [$];
  logic [15:0] frq  [$];
  logic        exp_err = 1'b0;
  logic [7:0]  shd [2][32];
  logic        prev_sclk = 1'b1;
  logic [1:0]  prev_cs = 2'b11;
  logic [15:0] shreg = '0;

  always #2.5 clk = ~clk;

  codec_wr_master #(.DLY_CYC(D)) i_codec_wr_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_masked(req_masked),
    .req_chip(req_chip), .req_reg(req_reg), .req_data(req_data),
    .req_mask(req_mask), .busy(busy), .done(done), .reject(reject),
    .err(err), .cs_n(cs_n), .sclk(sclk), .sdata(sdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, cyc, act, expv);
    end
  endtask

  // per-cycle reference comparison
  always @(negedge clk) begin
    logic [6:0] e;
    if (!rst) begin
      e = (expq.size() != 0) ? expq.pop_front() : 7'b000_11_1_1;
      chk(cs_n == e[3:2], "R3 R6 cs_n", cs_n, e[3:2]);
      chk(sclk == e[1], "R4 R10 sclk", sclk, e[1]);
      chk(sdata == e[0], "R1 R4 sdata", sdata, e[0]);
      chk(busy == e[6], "R5 busy", busy, e[6]);
      chk(done == e[5], "R5 done", done, e[5]);
      chk(reject == e[4], "R6 reject", reject, e[4]);
      chk(err == exp_err, "R9 err", err, exp_err);
      // frame monitor: capture on clock rise while selected
      if (cs_n != 2'b11 && sclk && !prev_sclk)
        shreg = {shreg[14:0], sdata};
      if (cs_n == 2'b11 && prev_cs != 2'b11) begin
        logic [15:0] ef;
        ef = (frq.size() != 0) ? frq.pop_front() : 16'hxxxx;
        chk(shreg === ef, "R1 R7 R8 frame", shreg, ef);
      end
    end
    prev_sclk = sclk;
    prev_cs   = cs_n;
  end

  task automatic push_chip(input int chip, input logic [15:0] fr);
    logic [1:0] csl;
    logic       pv;
    csl = ~(2'b01 << chip);
    for (int m = 0; m < 1 + 2*D; m++)
      expq.push_back((m < 1 + D) ? 7'b100_11_1_1 : {3'b100, csl, 2'b11});
    for (int i = 0; i < 16; i++) begin
      pv = (i == 0) ? 1'b1 : fr[16 - i];
      for (int k = 0; k < D; k++) expq.push_back({3'b100, csl, 1'b0, pv});
      for (int k = 0; k < D; k++) expq.push_back({3'b100, csl, 1'b0, fr[15-i]});
      for (int k = 0; k < D; k++) expq.push_back({3'b100, csl, 1'b1, fr[15-i]});
    end
    for (int k = 0; k < D; k++) expq.push_back(7'b100_11_1_1);
    frq.push_back(fr);
  endtask

  task automatic issue(input bit msk, input int chip, input int rg,
                       input logic [7:0] dat, input logic [7:0] mk);
    @(posedge clk); #1;
    req_valid = 1'b1; req_masked = msk; req_chip = 2'(chip);
    req_reg = 5'(rg); req_data = dat; req_mask = mk;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic request(input bit msk, input int chip, input int rg,
                         input logic [7:0] dat, input logic [7:0] mk);
    logic [7:0] nb;
    issue(msk, chip, rg, dat, mk);
    if (!msk && chip > 1) begin
      expq.push_back(7'b001_11_1_1);
    end else if (!msk) begin
      shd[chip][rg] = dat;
      push_chip(chip, {2'b10, 1'b1, 5'(rg), dat});
      expq.push_back(7'b010_11_1_1);
    end else begin
      for (int c = 0; c < 2; c++) begin
        nb = (shd[c][rg] & ~mk) | dat;
        shd[c][rg] = nb;
        push_chip(c, {2'b10, 1'b1, 5'(rg), nb});
      end
      expq.push_back(7'b010_11_1_1);
    end
  endtask

  task automatic wait_idle();
    while (expq.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 32; r++) shd[c][r] = 8'h00;
    exp_err = 1'b0;
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired cycle=%0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk); #0.5;
    // R2 reset state
    chk(cs_n == 2'b11 && sclk && sdata, "R2 lines", {cs_n, sclk, sdata}, 4'hF);
    chk(!busy && !done && !reject && !err, "R2 flags",
        {busy, done, reject, err}, 0);

    request(1'b0, 0, 5, 8'hA5, 8'h00);           // R1 R3 chip 0
    wait_idle();
    request(1'b0, 1, 31, 8'h3C, 8'h00);          // R3 chip 1, top register
    wait_idle();
    request(1'b0, 2, 4, 8'h11, 8'h00);           // R6 out of range
    wait_idle();
    request(1'b0, 3, 4, 8'h22, 8'h00);           // R6 out of range
    wait_idle();
    request(1'b1, 2, 5, 8'h03, 8'h0F);           // R7 R8: A3 then 03
    wait_idle();
    request(1'b1, 0, 5, 8'h50, 8'hF0);           // R7: 53 then 53
    repeat (40) @(posedge clk);
    issue(1'b0, 0, 0, 8'hFF, 8'h00);             // R9 ignored while busy
    exp_err = 1'b1;
    wait_idle();
    request(1'b1, 0, 0, 8'h00, 8'h00);           // R9: register 0 still 00
    wait_idle();
    do_reset();                                  // R8 shadow cleared
    request(1'b1, 0, 5, 8'h00, 8'h00);
    wait_idle();
    request(1'b0, 1, 0, 8'h81, 8'h00);
    wait_idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule